// File: doc/BRIEF.md
# Nibble-Serial Transmit Word Splitter

This block sits on the controller side of a full-duplex link to a data converter whose transmit port is half a word wide. It accepts parallel transmit samples through a valid/ready handshake and sends each one as two consecutive nibbles on a narrow bus. A sync line runs beside the bus, and its level tells the far end which nibble opens a word. The block runs on the interface clock supplied by the converter. That same clock also times the receive direction.

The far end can be reconfigured at run time, so four configuration inputs follow it:
- the order of the two nibbles;
- the sync level that marks the opening nibble;
- twos complement or straight binary samples;
- the clock edge on which the outputs are launched.

Each word uses the configuration captured when the word is accepted. A change made while a word is in flight therefore cannot split one word across two formats. The word width is a parameter and the nibble is always half of it. The default is a 12-bit word; a 10-bit word gives 5-bit nibbles.

Top module: `tx_nib_splitter`

## Requirements
- R1: While reset is high and on the first cycle after it, `tx_data` is all zeros, `tx_sync` is 1 and `in_ready` is 1.
- R2: A word is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for exactly the next cycle and then returns to 1. At most one word is taken every two cycles, and a source that holds `in_valid` at 1 gets one word every two cycles with no gap on the bus.
- R3: With `cfg_lsb_first` = 0 the opening nibble is word bits [W-1:W/2] and the closing nibble is bits [W/2-1:0]. With `cfg_lsb_first` = 1 the two are swapped.
- R4: With `cfg_sync_high` = 0, `tx_sync` is 0 during the opening nibble and 1 during the closing nibble. With `cfg_sync_high` = 1 both levels are inverted.
- R5: With `cfg_offset_bin` = 1, word bit W-1 is inverted before the word is split. With 0 the word is sent unchanged, as twos complement.
- R6: With `cfg_neg_edge` = 0 the outputs change just after a rising edge. With 1 they carry the same values but change at the following falling edge, half a cycle later.
- R7: When no word is in flight, `tx_data` keeps its last value and `tx_sync` stays at the closing-nibble level of the last word. After reset that level is 1.
- R8: All four configuration inputs are captured on the accepting edge and apply to that whole word. Changes at any other time have no effect until the next acceptance.
- R9: For a rising-edge launch, the opening nibble is on the bus in the cycle after the accepting edge and the closing nibble in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock from the converter |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A transmit word is offered |
| in_data | input | WORD_W | Transmit word, twos complement |
| in_ready | output | 1 | Block can take a word on this edge |
| cfg_lsb_first | input | 1 | 1: low half goes first |
| cfg_sync_high | input | 1 | 1: opening nibble marked by sync high |
| cfg_offset_bin | input | 1 | 1: send straight binary |
| cfg_neg_edge | input | 1 | 1: launch outputs on the falling edge |
| tx_data | output | WORD_W/2 | Nibble bus |
| tx_sync | output | 1 | Word-start marker |

## Verification
A wrong phase bit shows up immediately as `in_ready` out of step with the one-word-in-two pattern. It also makes `tx_sync` fail to alternate within one cycle, and the far end would read every word after it misaligned. A wrongly held closing nibble or configuration register shows up on the very next closing nibble: the data is wrong, or a word mixes two formats. The bench runs a cycle-level reference model against the ports every cycle. It samples twice per cycle so that a launch-edge fault is visible within half a cycle.

// File: rtl/tx_nib_pkg.sv
package tx_nib_pkg;

    typedef struct packed {
        logic lsb_first;
        logic sync_high;
        logic offset_bin;
        logic neg_edge;
    } nib_cfg_t;

    localparam nib_cfg_t CFG_RESET = '0;

    typedef enum logic {
        PH_IDLE_OR_FIRST = 1'b0,
        PH_SECOND        = 1'b1
    } nib_phase_e;

    // level of the sync line for the opening (first=1) or closing nibble
    function automatic logic sync_level(input logic sync_high, input logic first);
        return first ? sync_high : ~sync_high;
    endfunction

endpackage

// File: rtl/tx_nib_fmt.sv
module tx_nib_fmt
    import tx_nib_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0]   word,
    input  nib_cfg_t            cfg,
    output logic [WORD_W/2-1:0] nib_first,
    output logic [WORD_W/2-1:0] nib_second
);
    localparam int NIB_W = WORD_W / 2;

    logic [WORD_W-1:0] conv;
    logic [NIB_W-1:0]  hi_half;
    logic [NIB_W-1:0]  lo_half;

    always_comb begin
        conv       = word ^ {cfg.offset_bin, {(WORD_W-1){1'b0}}};
        hi_half    = conv[WORD_W-1:NIB_W];
        lo_half    = conv[NIB_W-1:0];
        nib_first  = cfg.lsb_first ? lo_half : hi_half;
        nib_second = cfg.lsb_first ? hi_half : lo_half;
    end
endmodule

// File: rtl/tx_nib_seq.sv
module tx_nib_seq
    import tx_nib_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  nib_cfg_t            cfg_in,
    input  logic [WORD_W/2-1:0] nib_first,
    input  logic [WORD_W/2-1:0] nib_second,
    output logic [WORD_W/2-1:0] q_data,
    output logic                q_sync,
    output nib_cfg_t            cfg_q
);
    localparam int NIB_W = WORD_W / 2;

    nib_phase_e       phase;
    logic [NIB_W-1:0] second_q;
    logic             accept;

    assign in_ready = (phase == PH_IDLE_OR_FIRST);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE_OR_FIRST;
            second_q <= '0;
            q_data   <= '0;
            q_sync   <= sync_level(CFG_RESET.sync_high, 1'b0);
            cfg_q    <= CFG_RESET;
        end else if (phase == PH_SECOND) begin
            q_data <= second_q;
            q_sync <= sync_level(cfg_q.sync_high, 1'b0);
            phase  <= PH_IDLE_OR_FIRST;
        end else if (accept) begin
            cfg_q    <= cfg_in;
            q_data   <= nib_first;
            second_q <= nib_second;
            q_sync   <= sync_level(cfg_in.sync_high, 1'b1);
            phase    <= PH_SECOND;
        end
    end
endmodule

// File: rtl/tx_nib_launch.sv
module tx_nib_launch #(
    parameter int NIB_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_neg,
    input  logic [NIB_W-1:0] d_data,
    input  logic             d_sync,
    output logic [NIB_W-1:0] o_data,
    output logic             o_sync
);
    logic [NIB_W-1:0] neg_data;
    logic             neg_sync;

    // half-cycle retiming copy for falling-edge launch
    always_ff @(negedge clk) begin
        if (rst) begin
            neg_data <= '0;
            neg_sync <= 1'b1;
        end else begin
            neg_data <= d_data;
            neg_sync <= d_sync;
        end
    end

    assign o_data = sel_neg ? neg_data : d_data;
    assign o_sync = sel_neg ? neg_sync : d_sync;
endmodule

// File: rtl/tx_nib_splitter.sv
module tx_nib_splitter
    import tx_nib_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    output logic                in_ready,
    input  logic                cfg_lsb_first,
    input  logic                cfg_sync_high,
    input  logic                cfg_offset_bin,
    input  logic                cfg_neg_edge,
    output logic [WORD_W/2-1:0] tx_data,
    output logic                tx_sync
);
    localparam int NIB_W = WORD_W / 2;

    nib_cfg_t         cfg_live;
    nib_cfg_t         cfg_q;
    logic [NIB_W-1:0] nib_first;
    logic [NIB_W-1:0] nib_second;
    logic [NIB_W-1:0] seq_data;
    logic             seq_sync;
    logic [3:0]       cfg_q_bits;

    always_comb begin
        cfg_live.lsb_first  = cfg_lsb_first;
        cfg_live.sync_high  = cfg_sync_high;
        cfg_live.offset_bin = cfg_offset_bin;
        cfg_live.neg_edge   = cfg_neg_edge;
    end

    assign cfg_q_bits = cfg_q;

    tx_nib_fmt #(.WORD_W(WORD_W)) u_fmt (
        .word       (in_data),
        .cfg        (cfg_live),
        .nib_first  (nib_first),
        .nib_second (nib_second)
    );

    tx_nib_seq #(.WORD_W(WORD_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .cfg_in     (cfg_live),
        .nib_first  (nib_first),
        .nib_second (nib_second),
        .q_data     (seq_data),
        .q_sync     (seq_sync),
        .cfg_q      (cfg_q)
    );

    tx_nib_launch #(.NIB_W(NIB_W)) u_launch (
        .clk     (clk),
        .rst     (rst),
        .sel_neg (cfg_q.neg_edge),
        .d_data  (seq_data),
        .d_sync  (seq_sync),
        .o_data  (tx_data),
        .o_sync  (tx_sync)
    );
endmodule

// File: rtl/tx_nib_splitter_chk.sv
module tx_nib_splitter_chk #(
    parameter int WORD_W = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic [WORD_W/2-1:0] q_data,
    input logic                q_sync,
    input logic [3:0]          cfg_q
);
    // R2: after an acceptance the port refuses the next cycle
    a_r2_gap_after_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R2: the refusal lasts one cycle only
    a_r2_ready_returns: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

    // R4: the closing nibble's sync differs from the opening one
    a_r4_sync_alternates: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> (q_sync != $past(q_sync)));

    // R7: with nothing offered the bus and sync hold
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> ($stable(q_data) && $stable(q_sync)));

    // R8: the captured configuration does not move during the closing nibble
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(cfg_q));
endmodule

bind tx_nib_splitter tx_nib_splitter_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .q_data   (seq_data),
    .q_sync   (seq_sync),
    .cfg_q    (cfg_q_bits)
);

// File: tb/tx_nib_splitter_tb.sv
module tx_nib_splitter_tb;
    localparam int WORD_W = 12;
    localparam int NIB_W  = WORD_W / 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [WORD_W-1:0] in_data;
    logic              in_ready;
    logic              cfg_lsb_first, cfg_sync_high, cfg_offset_bin, cfg_neg_edge;
    logic [NIB_W-1:0]  tx_data;
    logic              tx_sync;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    tx_nib_splitter #(.WORD_W(WORD_W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cfg_lsb_first(cfg_lsb_first),
        .cfg_sync_high(cfg_sync_high), .cfg_offset_bin(cfg_offset_bin),
        .cfg_neg_edge(cfg_neg_edge), .tx_data(tx_data), .tx_sync(tx_sync)
    );

    // reference model state
    logic             m_second_pending;
    logic [NIB_W-1:0] m_data, m_hold, m_prev_data;
    logic             m_sync, m_prev_sync, m_sync_high, m_neg;

    function automatic logic [NIB_W-1:0] exp_nib(input logic [WORD_W-1:0] w,
            input logic offb, input logic lsbf, input logic first);
        logic [WORD_W-1:0] c;
        c = w;
        if (offb) c[WORD_W-1] = ~c[WORD_W-1];                 // R5
        if (first ^ lsbf) return c[WORD_W-1:NIB_W];          // R3
        return c[NIB_W-1:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        m_prev_data = m_data;
        m_prev_sync = m_sync;
        if (m_second_pending) begin
            m_data = m_hold;                                   // R9 closing nibble
            m_sync = ~m_sync_high;
            m_second_pending = 1'b0;
        end else if (in_valid) begin
            // R8 configuration captured with the word
            m_sync_high = cfg_sync_high;
            m_neg       = cfg_neg_edge;
            m_data = exp_nib(in_data, cfg_offset_bin, cfg_lsb_first, 1'b1);
            m_hold = exp_nib(in_data, cfg_offset_bin, cfg_lsb_first, 1'b0);
            m_sync = cfg_sync_high;                            // R4
            m_second_pending = 1'b1;
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        #1;
        // R6 half a cycle after the rising edge a falling-edge launch still shows the old values
        check("R6 early data", tx_data, m_neg ? m_prev_data : m_data);
        check("R6 early sync", tx_sync, m_neg ? m_prev_sync : m_sync);
        #2;
        check("R3 R5 R8 R9 data", tx_data, m_data);
        check("R4 R7 sync", tx_sync, m_sync);
        check("R2 ready", in_ready, !m_second_pending);
    endtask

    task automatic rand_cfg();
        if ($urandom_range(3) == 0) cfg_lsb_first  = ~cfg_lsb_first;
        if ($urandom_range(3) == 0) cfg_sync_high  = ~cfg_sync_high;
        if ($urandom_range(3) == 0) cfg_offset_bin = ~cfg_offset_bin;
        if ($urandom_range(3) == 0) cfg_neg_edge   = ~cfg_neg_edge;
    endtask

    initial begin
        #400000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        cfg_lsb_first = 0; cfg_sync_high = 0; cfg_offset_bin = 0; cfg_neg_edge = 0;
        m_second_pending = 0; m_data = '0; m_hold = '0; m_sync = 1'b1;
        m_prev_data = '0; m_prev_sync = 1'b1; m_sync_high = 0; m_neg = 0;
        repeat (3) @(posedge clk);
        #3;
        check("R1 reset data", tx_data, 0);
        check("R1 reset sync", tx_sync, 1);
        check("R1 reset ready", in_ready, 1);
        rst = 1'b0;

        // R1 first cycle after reset, idle
        cycle();

        // R2 back-to-back stream, default configuration, signed corners
        in_valid = 1'b1;
        for (int i = 0; i < 16; i++) begin
            case (i % 4)
                0: in_data = 12'h800;
                1: in_data = 12'h7FF;
                2: in_data = 12'hFFF;
                default: in_data = 12'h000;
            endcase
            cycle();
        end

        // R5 R3 corners with straight binary and low half first
        cfg_offset_bin = 1; cfg_lsb_first = 1; in_data = 12'hFC0;
        for (int i = 0; i < 4; i++) cycle();

        // R7 idle: bus and sync hold
        in_valid = 1'b0;
        for (int i = 0; i < 6; i++) cycle();

        // R6 falling-edge launch with inverted sync (R4)
        cfg_neg_edge = 1; cfg_sync_high = 1; in_valid = 1'b1; in_data = 12'hA5C;
        for (int i = 0; i < 6; i++) cycle();

        // constrained random: cfg moves at any time (R8)
        for (int i = 0; i < 3000; i++) begin
            in_valid = ($urandom_range(9) < 7);
            in_data  = WORD_W'($urandom);
            rand_cfg();
            cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule